// File: doc/BRIEF.md
# Aligned Mixed-Length Instruction Splitter

This block sits between an instruction memory and a one-instruction-at-a-time decoder. The memory delivers naturally aligned 64-bit words, and the block asks for them with an aligned word address. Each buffered word is split into 32-bit slots. A slot whose two low bits are `11` is an ordinary 32-bit base instruction. Compressed instructions do not exist here, so any other prefix (`00`, `01`, `10`) in the lower slot of a word marks a 64-bit instruction that occupies the whole word.

A 64-bit instruction may only begin on a 64-bit boundary. Code generators keep that rule by placing a 32-bit NOP (`0x00000013`) in the odd slot in front of it. The NOP carries no special treatment and leaves the block like any other 32-bit instruction. A non-`11` prefix in the upper slot breaks the alignment rule. In that case the block emits nothing, raises a fault that carries the offending address, and stalls until the next redirect.

A redirect input loads a new program counter and drops whatever word is buffered. When the target points at the upper slot of a word, the lower slot of that word is never emitted.

Top module: `isplit_top`

## Requirements
- R1: After reset the block presents no instruction and no fault, asserts `fetch_ready`, and requests the word at `RESET_PC` (0 by default).
- R2: A slot whose bits [1:0] equal `11` is emitted with `out_is64` = 0, the slot in `out_instr[31:0]`, zeros in `out_instr[63:32]`, and its address in `out_pc`.
- R3: A lower slot (address bit 2 = 0) whose prefix is `00`, `01` or `10` is emitted as a 64-bit instruction. `out_is64` is 1, `out_instr` holds the whole word with the lower slot in bits [31:0], and `out_pc` is the word's aligned address.
- R4: On each accepted output the program counter advances by 4 for a 32-bit instruction and by 8 for a 64-bit one. `fetch_addr` is always the program counter with bits [2:0] cleared.
- R5: An upper slot (address bit 2 = 1) whose prefix is not `11` raises `fault_valid` with `fault_pc` equal to that slot's address. While the fault holds, the block emits nothing and fetches nothing. The fault and its address hold until a redirect.
- R6: A redirect loads the program counter with `redirect_pc` (bits [1:0] treated as zero), discards the buffered word, and clears a pending fault. During the redirect cycle `out_valid` and `fetch_ready` are low.
- R7: After a redirect to an upper slot, the first instruction emitted is the upper slot of that word. The lower slot is skipped whatever its prefix.
- R8: A NOP `0x00000013` in an odd slot is emitted as an ordinary 32-bit instruction, and the 64-bit instruction in the next word follows it.
- R9: While `out_valid` is high and `out_ready` is low, and no redirect occurs, the output stays valid and `out_instr`, `out_is64` and `out_pc` hold their values.
- R10: At most one fetch word is buffered. `fetch_ready` is high only when no word is buffered, no fault is pending and no redirect is present, so it is never high together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_valid | input | 1 | Load a new program counter this cycle |
| redirect_pc | input | ADDR_W | Redirect target address |
| fetch_addr | output | ADDR_W | Aligned address of the word wanted |
| fetch_ready | output | 1 | Block can take a fetch word |
| fetch_valid | input | 1 | Memory presents the word for `fetch_addr` |
| fetch_data | input | 64 | Fetch word, lower slot in bits [31:0] |
| out_valid | output | 1 | An instruction is presented |
| out_ready | input | 1 | Decoder takes the instruction |
| out_instr | output | 64 | Instruction bits, upper half zero for 32-bit |
| out_is64 | output | 1 | Instruction is 64 bits long |
| out_pc | output | ADDR_W | Address of the presented instruction |
| fault_valid | output | 1 | Misaligned wide instruction detected |
| fault_pc | output | ADDR_W | Address of the faulting slot |

## Verification
The assertions take for granted that `fetch_data` is the word at the address shown on `fetch_addr` in the same cycle. They also assume that a redirect lasts a single cycle and targets a 4-byte-aligned address. The bench meets the first by reading a combinational memory at `fetch_addr`. It meets the second by driving every redirect for exactly one cycle with a slot-aligned target. Beyond that, `fetch_valid` and `out_ready` toggle freely, so stalls on both sides land on every kind of slot, including the cycle in which a fault is found.

// File: rtl/isplit_pkg.sv
package isplit_pkg;

    // width of one base-format instruction slot
    localparam int INSN_W = 32;

    // prefix value that marks a base-format slot
    localparam logic [1:0] BASE_PREFIX = 2'b11;

    typedef enum logic [1:0] {
        SLOT_EMIT32 = 2'd0,
        SLOT_EMIT64 = 2'd1,
        SLOT_FAULT  = 2'd2
    } slot_kind_e;

endpackage

// File: rtl/isplit_classify.sv
module isplit_classify
    import isplit_pkg::*;
(
    input  logic [2*INSN_W-1:0] word_i,
    input  logic                odd_slot_i,
    output slot_kind_e          kind_o,
    output logic [2*INSN_W-1:0] instr_o
);

    logic [INSN_W-1:0] half_w;

    always_comb begin
        half_w = odd_slot_i ? word_i[2*INSN_W-1:INSN_W] : word_i[INSN_W-1:0];
        if (half_w[1:0] == BASE_PREFIX) begin
            kind_o  = SLOT_EMIT32;
            instr_o = {{INSN_W{1'b0}}, half_w};
        end else if (!odd_slot_i) begin
            kind_o  = SLOT_EMIT64;
            instr_o = word_i;
        end else begin
            kind_o  = SLOT_FAULT;
            instr_o = '0;
        end
    end

endmodule

// File: rtl/isplit_pc_step.sv
module isplit_pc_step
    import isplit_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              wide_i,
    output logic [ADDR_W-1:0] pc_next_o,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic              odd_slot_o
);

    localparam int SLOT_BYTES = INSN_W / 8;
    localparam int WORD_BYTES = 2 * SLOT_BYTES;
    localparam int SLOT_LSB   = $clog2(SLOT_BYTES);
    localparam int WORD_LSB   = $clog2(WORD_BYTES);

    always_comb begin
        pc_next_o   = pc_i + (wide_i ? ADDR_W'(WORD_BYTES) : ADDR_W'(SLOT_BYTES));
        word_addr_o = {pc_i[ADDR_W-1:WORD_LSB], {WORD_LSB{1'b0}}};
        odd_slot_o  = pc_i[SLOT_LSB];
    end

endmodule

// File: rtl/isplit_top.sv
module isplit_top
    import isplit_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                redirect_valid,
    input  logic [ADDR_W-1:0]   redirect_pc,
    output logic [ADDR_W-1:0]   fetch_addr,
    output logic                fetch_ready,
    input  logic                fetch_valid,
    input  logic [2*INSN_W-1:0] fetch_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [2*INSN_W-1:0] out_instr,
    output logic                out_is64,
    output logic [ADDR_W-1:0]   out_pc,
    output logic                fault_valid,
    output logic [ADDR_W-1:0]   fault_pc
);

    localparam int WORD_W   = 2 * INSN_W;
    localparam int SLOT_LSB = $clog2(INSN_W / 8);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] word;
        logic              word_vld;
        logic              faulted;
    } state_t;

    state_t s_d, s_q;

    slot_kind_e        kind_w;
    logic [WORD_W-1:0] instr_w;
    logic [ADDR_W-1:0] pc_next_w;
    logic [ADDR_W-1:0] word_addr_w;
    logic              odd_w;

    isplit_pc_step #(.ADDR_W(ADDR_W)) u_step (
        .pc_i        (s_q.pc),
        .wide_i      (kind_w == SLOT_EMIT64),
        .pc_next_o   (pc_next_w),
        .word_addr_o (word_addr_w),
        .odd_slot_o  (odd_w)
    );

    isplit_classify u_class (
        .word_i     (s_q.word),
        .odd_slot_i (odd_w),
        .kind_o     (kind_w),
        .instr_o    (instr_w)
    );

    always_comb begin
        s_d         = s_q;
        fetch_ready = !s_q.word_vld && !s_q.faulted && !redirect_valid;
        out_valid   = s_q.word_vld && (kind_w != SLOT_FAULT) && !redirect_valid;

        if (redirect_valid) begin
            s_d.pc       = {redirect_pc[ADDR_W-1:SLOT_LSB], {SLOT_LSB{1'b0}}};
            s_d.word_vld = 1'b0;
            s_d.faulted  = 1'b0;
        end else if (fetch_ready && fetch_valid) begin
            s_d.word     = fetch_data;
            s_d.word_vld = 1'b1;
        end else if (s_q.word_vld) begin
            if (kind_w == SLOT_FAULT) begin
                s_d.faulted  = 1'b1;
                s_d.word_vld = 1'b0;
            end else if (out_ready) begin
                s_d.pc = pc_next_w;
                if (kind_w == SLOT_EMIT64 || odd_w) begin
                    s_d.word_vld = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.pc       <= RESET_PC;
            s_q.word     <= '0;
            s_q.word_vld <= 1'b0;
            s_q.faulted  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fetch_addr  = word_addr_w;
    assign out_instr   = instr_w;
    assign out_is64    = (kind_w == SLOT_EMIT64);
    assign out_pc      = s_q.pc;
    assign fault_valid = s_q.faulted;
    assign fault_pc    = s_q.pc;

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !redirect_valid
        |=> out_valid && $stable(out_instr) && $stable(out_pc) && $stable(out_is64));

    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid && !redirect_valid |=> fault_valid && $stable(fault_pc));

    // R5
    fault_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> !out_valid && !fetch_ready);

    // R3
    wide_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_is64 |-> out_pc[SLOT_LSB] == 1'b0);

    // R4
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !redirect_valid
        |=> s_q.pc == $past(s_q.pc) + ($past(out_is64) ? ADDR_W'(8) : ADDR_W'(4)));

    // R10
    fetch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |-> !out_valid);

    // R6
    redirect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !fault_valid && !out_valid);

endmodule

// File: tb/isplit_top_test.sv
module isplit_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect_valid = 1'b0;
    logic [31:0] redirect_pc = '0;
    logic [31:0] fetch_addr;
    logic        fetch_ready;
    logic        fetch_valid = 1'b0;
    logic [63:0] fetch_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_instr;
    logic        out_is64;
    logic [31:0] out_pc;
    logic        fault_valid;
    logic [31:0] fault_pc;

    int checks = 0;
    int errors = 0;
    bit rand_on = 1'b0;

    logic [63:0] mem [0:15];
    logic [31:0] q_pc  [$];
    logic [63:0] q_ins [$];
    bit          q_w   [$];
    logic [31:0] exp_fault_pc;
    int          popped;

    bit          prev_stall = 1'b0;
    logic [63:0] prev_ins;
    logic [31:0] prev_pc;
    bit          prev_w;

    always #10 clk = ~clk;

    assign fetch_data = mem[fetch_addr[6:3]];

    isplit_top uut (
        .clk(clk), .rst_n(rst_n),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_instr(out_instr), .out_is64(out_is64), .out_pc(out_pc),
        .fault_valid(fault_valid), .fault_pc(fault_pc)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural walk of the program from a start address, per R2/R3/R5
    task automatic build(input logic [31:0] start);
        logic [31:0] pc;
        logic [31:0] half;
        logic [63:0] w;
        q_pc.delete(); q_ins.delete(); q_w.delete();
        pc = start;
        popped = 0;
        exp_fault_pc = '1;
        for (int n = 0; n < 64; n++) begin
            w = mem[pc[6:3]];
            half = pc[2] ? w[63:32] : w[31:0];
            if (half[1:0] == 2'b11) begin
                q_pc.push_back(pc); q_ins.push_back({32'h0, half}); q_w.push_back(1'b0);
                pc = pc + 32'd4;
            end else if (!pc[2]) begin
                q_pc.push_back(pc); q_ins.push_back(w); q_w.push_back(1'b1);
                pc = pc + 32'd8;
            end else begin
                exp_fault_pc = pc;
                break;
            end
        end
    endtask

    // inputs change 2 time units after the rising edge
    always @(posedge clk) begin
        #2;
        if (rand_on) begin
            out_ready   <= ($urandom % 3) != 0;
            fetch_valid <= ($urandom % 2) != 0;
        end
    end

    // cycle-by-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(out_valid && out_instr == prev_ins && out_pc == prev_pc && out_is64 == prev_w,
                    "R9 held output", {out_pc, out_instr[31:0]}, {prev_pc, prev_ins[31:0]});
            end
            if (fetch_ready) begin
                chk(!out_valid && fetch_addr[2:0] == 3'b000, "R10 fetch while idle",
                    {31'h0, out_valid, fetch_addr}, 64'h0);
            end
            if (redirect_valid) begin
                chk(!out_valid && !fetch_ready, "R6 quiet during redirect",
                    {62'h0, out_valid, fetch_ready}, 64'h0);
            end
            if (out_valid && out_ready) begin
                if (q_pc.size() == 0) begin
                    chk(1'b0, "R2/R3 unexpected output", {32'h0, out_pc}, 64'h0);
                end else begin
                    chk(out_pc == q_pc[0], "R4 instruction address", {32'h0, out_pc}, {32'h0, q_pc[0]});
                    chk(out_is64 == q_w[0], q_w[0] ? "R3 length flag" : "R2 length flag",
                        {63'h0, out_is64}, {63'h0, q_w[0]});
                    chk(out_instr == q_ins[0],
                        q_w[0] ? "R3 wide bits" : (q_ins[0] == 64'h13 ? "R8 padding NOP" : "R2 base bits"),
                        out_instr, q_ins[0]);
                    void'(q_pc.pop_front()); void'(q_ins.pop_front()); void'(q_w.pop_front());
                    popped++;
                end
            end
            prev_stall = out_valid && !out_ready && !redirect_valid;
            prev_ins   = out_instr;
            prev_pc    = out_pc;
            prev_w     = out_is64;
        end
    end

    task automatic redirect_to(input logic [31:0] tgt);
        @(posedge clk); #2;
        redirect_valid = 1'b1;
        redirect_pc    = tgt;
        build(tgt);
        @(posedge clk); #2;
        redirect_valid = 1'b0;
        @(negedge clk);
        chk(!fault_valid && !out_valid, "R6 fault and buffer cleared",
            {62'h0, fault_valid, out_valid}, 64'h0);
    endtask

    task automatic drain(input string req);
        int t = 0;
        while (!(q_pc.size() == 0 && fault_valid) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 3000, {req, " drain"}, 64'(q_pc.size()), 64'h0);
        chk(fault_valid && fault_pc == exp_fault_pc, {req, "/R5 fault address"},
            {32'h0, fault_pc}, {32'h0, exp_fault_pc});
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = {32'h0000_0000, 32'h0000_0013};
        mem[0] = {32'h0000_0013, 32'h0050_0093};
        mem[1] = {32'h9ABC_DEF0, 32'h1234_5678};
        mem[2] = {32'h1111_2222, 32'h0000_0A05};
        mem[3] = {32'h3333_4444, 32'h0000_0B06};
        mem[4] = {32'h4020_8233, 32'h0020_81B3};
        mem[5] = {32'h0000_0000, 32'h0000_0013};
        mem[6] = {32'h0030_0113, 32'hDEAD_BEE0};
        mem[7] = {32'h5555_6666, 32'h0000_0C01};

        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!out_valid && !fault_valid && fetch_ready && fetch_addr == 32'h0, "R1 reset state",
            {29'h0, out_valid, fault_valid, fetch_ready, fetch_addr}, {31'h0, 1'b1, 32'h0});

        build(32'h0);
        rand_on = 1'b1;
        drain("R2/R3/R8 main program");
        chk(popped == 8, "R4 instruction count", 64'(popped), 64'd8);

        repeat (10) @(negedge clk);
        chk(fault_valid && fault_pc == 32'h2C && !out_valid && !fetch_ready, "R5 fault held",
            {30'h0, fault_valid, out_valid, fault_pc}, {31'h0, 1'b1, 32'h2C});

        redirect_to(32'h34);
        drain("R7 odd-slot entry");
        chk(popped == 3, "R7 lower slot skipped", 64'(popped), 64'd3);

        redirect_to(32'h0);
        while (popped < 3) @(negedge clk);
        redirect_to(32'h20);
        drain("R6 mid-stream redirect");
        chk(popped == 3, "R6 count after redirect", 64'(popped), 64'd3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule